// File: doc/BRIEF.md
# Receiver Wake-Up Sequencer and Timing Generator

This block runs from the receiver's crystal-rate clock. It produces the receiver's digital timing ticks and steps the receiver from sleep, through a warm-up interval, into data reception. A basic tick is derived from the crystal clock by a divider whose ratio depends on the band-select input. An extended tick groups one, two, four or eight basic ticks according to the data-rate range.

When the wake input is raised, the block latches the band and rate selections and starts a warm-up timer. The timer counts half basic-tick periods, so that warm-up lengths ending in half a period come out exact. When warm-up ends, the block waits for a falling edge on the raw demodulator bit. Only then does it open the gate that passes demodulated data to the output, so that the first released transition lines up with a real data edge. Lowering the wake input returns the block to sleep on the next clock, from any state.

The four states are SLEEP (code 0), WARMUP (code 1), ARMED (code 2, warm-up done, waiting for an edge) and RECV (code 3, data released). The transitions are:
- SLEEP→WARMUP when the wake input is high.
- WARMUP→ARMED when the timer expires.
- ARMED→RECV on a demodulator falling edge.
- Any state→SLEEP when the wake input is low.

Top module: `rx_startup_seq`

## Requirements
- R1: A clock edge with `rst_n` low forces state_o to 0 (SLEEP), clears all counters and drives every tick, the analog flag and the data gate to 0.
- R2: While in SLEEP, base_tick_o, ext_tick_o, analog_on_o and data_gate_o stay 0.
- R3: Cycle 0 is the first cycle with state_o = 1. Counting from cycle 0, base_tick_o pulses for one cycle in every cycle k where (k+1) is a multiple of 2·D. D is 5 when the latched band bit is 0 and 7 when it is 1, so the basic period is 10 or 14 clocks.
- R4: ext_tick_o pulses only together with base_tick_o, in cycles where (k+1) is a multiple of 2·D·M. M is 8, 4, 2 or 1 for rate_sel_i codes 00, 01, 10 and 11.
- R5: state_o stays 1 (WARMUP) for exactly H·D cycles and then becomes 2 (ARMED). H is the half-period count: 1793, 1025, 1025 or 641 for rate codes 00, 01, 10 and 11.
- R6: mode_i and rate_sel_i are sampled only on the SLEEP→WARMUP transition. Changes made to them afterwards have no effect on tick spacing or warm-up length.
- R7: data_gate_o is 0 in WARMUP and ARMED. A falling edge occurs when demod_i was 1 in one cycle and is 0 in the next. A falling edge seen in ARMED moves the block to RECV (state 3) with data_gate_o = 1 on the following cycle. A rising edge, or a falling edge during WARMUP, does not open the gate.
- R8: In RECV, state_o stays 3 and data_gate_o stays 1 while enable_i is high, whatever demod_i does.
- R9: enable_i low in WARMUP, ARMED or RECV puts the block in SLEEP on the next cycle. A later wake-up restarts the warm-up timer from zero and runs the full R5 length.
- R10: analog_on_o is 1 in states 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Wake input: high runs the receiver, low means sleep |
| mode_i | input | 1 | Band select: 0 gives divide by 10, 1 gives divide by 14 |
| rate_sel_i | input | 2 | Data-rate range select, codes 00 to 11 |
| demod_i | input | 1 | Raw demodulator bit |
| base_tick_o | output | 1 | One-cycle basic clock tick |
| ext_tick_o | output | 1 | One-cycle extended clock tick |
| state_o | output | 2 | Sequencer state code |
| analog_on_o | output | 1 | Analog processing enable |
| data_gate_o | output | 1 | High when demodulated data may pass to the output |

## Verification
All eight band and rate combinations are walked through warm-up under steady inputs. Per-cycle tick checks tell apart a wrong divider ratio, a wrong multiplier and a wrong warm-up length. Further warm-ups run with mode_i, rate_sel_i and demod_i scrambled by a fixed-seed generator, which would expose any sampling of the selects after wake-up and any premature opening of the gate. Directed cases separate a rising edge from a falling edge in ARMED, and cover an abort part way through warm-up followed by a full-length restart, a drop out of ARMED and RECV, and a reset while receiving.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_WARMUP = 2'd1,
        ST_ARMED  = 2'd2,
        ST_RECV   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rxseq_prescaler.sv
// Half-tick and basic-tick generator; ratio picked by the band bit.
module rxseq_prescaler #(
    parameter int unsigned HALF_LO = 5,
    parameter int unsigned HALF_HI = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_hi,
    output logic half_tick,
    output logic base_tick
);
    localparam int unsigned HMAX = (HALF_HI > HALF_LO) ? HALF_HI : HALF_LO;
    localparam int unsigned CW   = $clog2(HMAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          phase;

    always_comb begin
        lim       = sel_hi ? CW'(HALF_HI - 1) : CW'(HALF_LO - 1);
        half_tick = run && (cnt == lim);
        base_tick = half_tick && phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == lim) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxseq_extdiv.sv
// Extended tick: every MAX_MULT >> range basic ticks.
module rxseq_extdiv #(
    parameter int unsigned MAX_MULT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       base_tick,
    input  logic [1:0] rng,
    output logic       ext_tick
);
    localparam int unsigned EW = (MAX_MULT > 2) ? $clog2(MAX_MULT) : 1;

    logic [EW-1:0] cnt;
    logic [EW-1:0] lim;

    always_comb begin
        lim      = EW'((MAX_MULT >> rng) - 1);
        ext_tick = base_tick && (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (base_tick) begin
            cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxseq_wake_timer.sv
// Warm-up timer counting half basic periods.
module rxseq_wake_timer #(
    parameter int unsigned LEN_R0 = 1793,
    parameter int unsigned LEN_R1 = 1025,
    parameter int unsigned LEN_R2 = 1025,
    parameter int unsigned LEN_R3 = 641
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       half_tick,
    input  logic [1:0] rng,
    output logic       done
);
    localparam int unsigned M01  = (LEN_R0 > LEN_R1) ? LEN_R0 : LEN_R1;
    localparam int unsigned M23  = (LEN_R2 > LEN_R3) ? LEN_R2 : LEN_R3;
    localparam int unsigned LMAX = (M01 > M23) ? M01 : M23;
    localparam int unsigned TW   = $clog2(LMAX);

    logic [TW-1:0] cnt;
    logic [TW-1:0] lim;

    always_comb begin
        unique case (rng)
            2'd0:    lim = TW'(LEN_R0 - 1);
            2'd1:    lim = TW'(LEN_R1 - 1);
            2'd2:    lim = TW'(LEN_R2 - 1);
            default: lim = TW'(LEN_R3 - 1);
        endcase
        done = run && half_tick && (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (half_tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rx_startup_seq.sv
module rx_startup_seq
    import rxseq_pkg::*;
#(
    parameter int unsigned HALF_LO  = 5,
    parameter int unsigned HALF_HI  = 7,
    parameter int unsigned MAX_MULT = 8,
    parameter int unsigned LEN_R0   = 1793,
    parameter int unsigned LEN_R1   = 1025,
    parameter int unsigned LEN_R2   = 1025,
    parameter int unsigned LEN_R3   = 641
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       mode_i,
    input  logic [1:0] rate_sel_i,
    input  logic       demod_i,
    output logic       base_tick_o,
    output logic       ext_tick_o,
    output logic [1:0] state_o,
    output logic       analog_on_o,
    output logic       data_gate_o
);
    seq_state_t state, nxt;
    logic       mode_r;
    logic [1:0] rng_r;
    logic       demod_q;
    logic       fall;
    logic       run;
    logic       half_tick;
    logic       base_tick;
    logic       warm_done;

    assign run  = (state != ST_SLEEP);
    assign fall = demod_q && !demod_i;

    rxseq_prescaler #(.HALF_LO(HALF_LO), .HALF_HI(HALF_HI)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .sel_hi(mode_r),
        .half_tick(half_tick), .base_tick(base_tick)
    );

    rxseq_extdiv #(.MAX_MULT(MAX_MULT)) u_ext (
        .clk(clk), .rst_n(rst_n), .run(run), .base_tick(base_tick),
        .rng(rng_r), .ext_tick(ext_tick_o)
    );

    rxseq_wake_timer #(
        .LEN_R0(LEN_R0), .LEN_R1(LEN_R1), .LEN_R2(LEN_R2), .LEN_R3(LEN_R3)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WARMUP),
        .half_tick(half_tick), .rng(rng_r), .done(warm_done)
    );

    // Selections latched at wake-up; demod history for edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r  <= 1'b0;
            rng_r   <= 2'd0;
            demod_q <= 1'b0;
        end else begin
            demod_q <= demod_i;
            if (state == ST_SLEEP && enable_i) begin
                mode_r <= mode_i;
                rng_r  <= rate_sel_i;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SLEEP:  if (enable_i) nxt = ST_WARMUP;
            ST_WARMUP: if (!enable_i) nxt = ST_SLEEP;
                       else if (warm_done) nxt = ST_ARMED;
            ST_ARMED:  if (!enable_i) nxt = ST_SLEEP;
                       else if (fall) nxt = ST_RECV;
            ST_RECV:   if (!enable_i) nxt = ST_SLEEP;
            default:   nxt = ST_SLEEP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= nxt;
    end

    // Outputs
    always_comb begin
        state_o     = state;
        base_tick_o = base_tick;
        analog_on_o = (state != ST_SLEEP);
        data_gate_o = (state == ST_RECV);
    end
endmodule

// File: rtl/rx_startup_seq_chk.sv
module rx_startup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       demod_i,
    input logic       base_tick_o,
    input logic       ext_tick_o,
    input logic [1:0] state_o,
    input logic       analog_on_o,
    input logic       data_gate_o
);
    // R2
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd0 |-> !base_tick_o && !ext_tick_o && !analog_on_o && !data_gate_o);

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick_o |=> !base_tick_o);

    // R4
    ext_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick_o |-> base_tick_o);

    // R9
    drop_to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> state_o == 2'd0);

    // R7
    gate_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_gate_o) |-> $past(state_o) == 2'd2 && $past(demod_i) == 1'b0);

    // R8
    recv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd3 && enable_i |=> state_o == 2'd3 && data_gate_o);
endmodule

bind rx_startup_seq rx_startup_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .demod_i(demod_i),
    .base_tick_o(base_tick_o), .ext_tick_o(ext_tick_o), .state_o(state_o),
    .analog_on_o(analog_on_o), .data_gate_o(data_gate_o)
);

// File: tb/rx_startup_seq_test.sv
`timescale 1ns/1ps
module rx_startup_seq_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable_i;
    logic       mode_i;
    logic [1:0] rate_sel_i;
    logic       demod_i;
    logic       base_tick_o;
    logic       ext_tick_o;
    logic [1:0] state_o;
    logic       analog_on_o;
    logic       data_gate_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_startup_seq uut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
        .rate_sel_i(rate_sel_i), .demod_i(demod_i), .base_tick_o(base_tick_o),
        .ext_tick_o(ext_tick_o), .state_o(state_o), .analog_on_o(analog_on_o),
        .data_gate_o(data_gate_o)
    );

    function automatic int exp_div(input bit m);
        return m ? 7 : 5;
    endfunction

    function automatic int exp_mult(input logic [1:0] r);
        return 8 >> r;
    endfunction

    function automatic int exp_half(input logic [1:0] r);
        case (r)
            2'd0:    return 1793;
            2'd1:    return 1025;
            2'd2:    return 1025;
            default: return 641;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Starts from SLEEP; returns with the block in ARMED
    task automatic do_warmup(input bit m, input logic [1:0] r, input bit scramble);
        int d = exp_div(m);
        int e = exp_mult(r);
        int len = exp_half(r) * d;
        int k = 0;
        int tick_bad = 0, ext_bad = 0, gate_bad = 0;
        mode_i = m; rate_sel_i = r; enable_i = 1'b1; demod_i = 1'b0;
        step();
        while (state_o == 2'd1 && k < len + 10) begin
            if (base_tick_o !== (((k + 1) % (2 * d)) == 0)) tick_bad++;
            if (ext_tick_o !== (((k + 1) % (2 * d * e)) == 0)) ext_bad++;
            if (data_gate_o !== 1'b0 || analog_on_o !== 1'b1) gate_bad++;
            if (scramble) begin
                mode_i     = 1'($urandom % 2);
                rate_sel_i = 2'($urandom % 4);
                demod_i    = (k < len - 3) ? 1'($urandom % 2) : 1'b0;
            end
            step();
            k++;
        end
        check(k == len, scramble ? "R6" : "R5", "warm-up cycles", k, len);
        check(state_o == 2'd2, "R5", "state after warm-up", state_o, 2);
        check(tick_bad == 0, "R3", "base tick mismatches", tick_bad, 0);
        check(ext_bad == 0, "R4", "ext tick mismatches", ext_bad, 0);
        check(gate_bad == 0, "R7", "gate/analog faults in warm-up (R10)", gate_bad, 0);
    endtask

    // In ARMED: rising edge must not open, falling edge must
    task automatic open_gate();
        int bad = 0;
        demod_i = 1'b0;
        repeat (3) step();
        check(state_o == 2'd2 && data_gate_o == 1'b0, "R7", "gate closed in ARMED",
              data_gate_o, 0);
        demod_i = 1'b1;
        step();
        check(state_o == 2'd2 && data_gate_o == 1'b0, "R7", "rising edge ignored",
              state_o, 2);
        demod_i = 1'b0;
        step();
        check(state_o == 2'd3 && data_gate_o == 1'b1, "R7", "falling edge opens gate",
              state_o, 3);
        check(analog_on_o == 1'b1, "R10", "analog on in RECV", analog_on_o, 1);
        for (int i = 0; i < 40; i++) begin
            demod_i = 1'($urandom % 2);
            step();
            if (state_o != 2'd3 || data_gate_o != 1'b1) bad++;
        end
        check(bad == 0, "R8", "RECV held under data", bad, 0);
    endtask

    task automatic go_sleep(input string why);
        enable_i = 1'b0;
        step();
        check(state_o == 2'd0 && data_gate_o == 1'b0 && analog_on_o == 1'b0,
              "R9", why, state_o, 0);
        step();
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL all watchdog expired actual=1 expected=0");
            summary();
        end
    end

    initial begin
        int quiet_bad = 0;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; enable_i = 1'b1; mode_i = 1'b0; rate_sel_i = 2'd0; demod_i = 1'b0;
        repeat (3) step();
        check(state_o == 2'd0 && !base_tick_o && !ext_tick_o && !analog_on_o && !data_gate_o,
              "R1", "reset outputs", state_o, 0);
        enable_i = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            demod_i = 1'($urandom % 2);
            step();
            if (state_o != 2'd0 || base_tick_o || ext_tick_o || analog_on_o || data_gate_o)
                quiet_bad++;
        end
        check(quiet_bad == 0, "R2", "sleep quiet", quiet_bad, 0);
        demod_i = 1'b0;
        step();

        // Directed: every band/rate combination
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < 4; r++) begin
                do_warmup(1'(m), 2'(r), 1'b0);
                open_gate();
                go_sleep("RECV to sleep");
            end
        end

        // Abort in warm-up, then a full-length restart
        mode_i = 1'b1; rate_sel_i = 2'd3; enable_i = 1'b1;
        repeat (150) step();
        check(state_o == 2'd1, "R9", "still warming before abort", state_o, 1);
        enable_i = 1'b0;
        step();
        check(state_o == 2'd0 && !base_tick_o && !analog_on_o, "R9", "abort to sleep",
              state_o, 0);
        do_warmup(1'b1, 2'd3, 1'b0);
        go_sleep("ARMED to sleep");

        // Random runs with scrambled selects and demod during warm-up
        for (int n = 0; n < 4; n++) begin
            do_warmup(1'($urandom % 2), 2'($urandom % 4), 1'b1);
            open_gate();
            go_sleep("random RECV to sleep");
        end

        // Reset while receiving
        do_warmup(1'b0, 2'd3, 1'b0);
        open_gate();
        rst_n = 1'b0;
        step();
        check(state_o == 2'd0 && !data_gate_o && !analog_on_o, "R1", "reset in RECV",
              state_o, 0);
        rst_n = 1'b1;
        step();
        check(state_o == 2'd1, "R5", "wake after reset release", state_o, 1);
        enable_i = 1'b0;
        repeat (2) step();

        summary();
    end
endmodule